// File: doc/BRIEF.md
# Serial Soft-Sample Link

This block sits between an external sample source and a trellis decoding core. The source sends two soft samples at a time, one bit per clock on each of two serial lines, qualified by a bit-valid strobe. The block assembles both samples, presents them to the core as one valid/ready pair, and asks the source for the next pair with a one-clock request pulse each time the core accepts one. If the core reaches its branch-metric step while no pair is held, the block raises a stall.

On the output side, the core reports each completed trellis stage and the bit it decoded for that stage. The block stays silent for a fixed number of stages after a run starts, because the survivor paths have not yet merged. After that it forwards one decoded bit per stage with a one-clock valid. When the run-enable input drops, the block stops requesting samples and emits exactly one more latency window of decoded bits. Then it goes idle.

Back-pressure rules for the sample pair: `pair_vld_o` stays high and both samples stay frozen until a cycle in which `pair_rdy_i` is also high. Serial bits that arrive while a pair is held are discarded. The source must not send a new pair until it sees `req_o`.

Top module: `soft_sample_link`

## Requirements
- R1: One clock after a rising edge is seen on `go_i`, `req_o` is high for exactly one clock. That same edge discards any held pair and any partly received bits.
- R2: While `go_i` is high and no pair is held, each clock with `bit_vld_i` high shifts one bit into each lane. `pair_vld_o` rises at the clock edge that takes in the third bit.
- R3: Bits arrive most significant first. The first bit of a pair lands in bit 2 of `x_smp_o` / `y_smp_o`, and the last bit lands in bit 0.
- R4: A clock in which `pair_vld_o` and `pair_rdy_i` are both high is an acceptance. `pair_vld_o` is low after it. If `go_i` was high during the acceptance, `req_o` pulses in the next clock.
- R5: `stall_o` is high exactly when `pair_rdy_i` is high and `pair_vld_o` is low.
- R6: While a pair is held and not accepted, serial bits have no effect: the samples and `pair_vld_o` do not change.
- R7: After a run starts, the first 16 `stage_done_i` pulses produce no output. Each later pulse gives `dec_vld_o` high in the next clock, with `dec_bit_o` equal to the `core_bit_i` that came with the pulse.
- R8: `req_o` is never high in two consecutive clocks. `dec_vld_o` is high only in the clock after a `stage_done_i` pulse.
- R9: After `go_i` falls, acceptances produce no `req_o` pulse.
- R10: After `go_i` falls, each of the next 16 `stage_done_i` pulses produces one output bit. After that the block is idle and ignores `stage_done_i`.
- R11: A new rising edge of `go_i` after a flush starts a new run, including a fresh 16-stage silent window.
- R12: During reset and right after it, `req_o`, `pair_vld_o`, `stall_o` and `dec_vld_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Run enable; a rising edge starts a run, a falling edge starts the flush |
| req_o | output | 1 | One-clock request for the next sample pair |
| x_ser_i | input | 1 | Serial bit of the first soft sample |
| y_ser_i | input | 1 | Serial bit of the second soft sample |
| bit_vld_i | input | 1 | Qualifies the serial bits, one bit per clock |
| x_smp_o | output | 3 | Assembled first sample |
| y_smp_o | output | 3 | Assembled second sample |
| pair_vld_o | output | 1 | Sample pair held and valid |
| pair_rdy_i | input | 1 | Core is at its branch-metric step and takes the pair |
| stall_o | output | 1 | Core must wait: it is ready but no pair is held |
| stage_done_i | input | 1 | Core finished one trellis stage |
| core_bit_i | input | 1 | Decoded bit for the stage that just finished |
| dec_bit_o | output | 1 | Decoded output bit |
| dec_vld_o | output | 1 | One-clock valid for `dec_bit_o` |

## Verification
The bench checks the edge of the silent window: output must appear first on the seventeenth stage after a start. A counter that is off by one would emit a bit one stage early or one stage late. It sends extra serial bits while a pair is held; a design that kept shifting would corrupt the held samples. After `go_i` falls, the bench accepts a pair and expects no request, which catches a design that keeps asking for data. It then counts exactly sixteen flushed bits and expects silence on the seventeenth stage, so a flush that never ends or ends early is reported. A restart must open a new silent window; a design that kept its old stage count would output at once.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  // Default geometry of the link
  localparam int unsigned SMP_W_DEF = 3;   // bits per soft sample
  localparam int unsigned LAT_DEF   = 16;  // stages before first output / flush length
  localparam int unsigned LANES     = 2;   // two parallel serial streams
endpackage

// File: rtl/ssl_lane.sv
module ssl_lane #(
  parameter int unsigned SMP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ser_i,
  output logic [SMP_W-1:0] smp_o
);
  logic [SMP_W-1:0] sh_q;

  // MSB first: earlier bits move toward the top as new ones enter at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[SMP_W-2:0], ser_i};
  end

  assign smp_o = sh_q;
endmodule

// File: rtl/ssl_pair_ctrl.sv
module ssl_pair_ctrl #(
  parameter int unsigned SMP_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic bit_vld_i,
  input  logic pair_rdy_i,
  output logic shift_en_o,
  output logic pair_vld_o,
  output logic req_o,
  output logic stall_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned BCW = (SMP_W > 1) ? $clog2(SMP_W) : 1;

  logic           go_q;
  logic           vld_q;
  logic           req_q;
  logic [BCW-1:0] bcnt_q;
  logic           take;

  assign rise_o     = go_i & ~go_q;
  assign fall_o     = ~go_i & go_q;
  assign shift_en_o = bit_vld_i & ~vld_q & go_i & ~rise_o;
  assign take       = vld_q & pair_rdy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      vld_q  <= 1'b0;
      req_q  <= 1'b0;
      bcnt_q <= '0;
    end else begin
      go_q  <= go_i;
      req_q <= rise_o | (take & go_i);
      if (rise_o) begin
        vld_q  <= 1'b0;
        bcnt_q <= '0;
      end else if (take) begin
        vld_q <= 1'b0;
      end else if (shift_en_o) begin
        if (bcnt_q == BCW'(SMP_W-1)) begin
          vld_q  <= 1'b1;
          bcnt_q <= '0;
        end else begin
          bcnt_q <= bcnt_q + BCW'(1);
        end
      end
    end
  end

  assign pair_vld_o = vld_q;
  assign req_o      = req_q;
  assign stall_o    = pair_rdy_i & ~vld_q;

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  assert_req_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(go_i));
  assert_fill_from_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(bit_vld_i));
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && pair_rdy_i) |=> !vld_q);
endmodule

// File: rtl/ssl_out_seq.sv
module ssl_out_seq #(
  parameter int unsigned LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic fall_i,
  input  logic stage_done_i,
  input  logic core_bit_i,
  output logic dec_bit_o,
  output logic dec_vld_o
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic          active_q;
  logic          flush_q;
  logic [CW-1:0] lat_q;
  logic [CW-1:0] fl_q;
  logic          vld_q;
  logic          bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flush_q  <= 1'b0;
      lat_q    <= '0;
      fl_q     <= '0;
      vld_q    <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (rise_i) begin
        active_q <= 1'b1;
        flush_q  <= 1'b0;
        lat_q    <= '0;
        fl_q     <= '0;
      end else begin
        if (fall_i && active_q) flush_q <= 1'b1;
        if (stage_done_i && active_q) begin
          if (flush_q) begin
            vld_q <= 1'b1;
            bit_q <= core_bit_i;
            if (fl_q == CW'(LAT-1)) begin
              active_q <= 1'b0;
              flush_q  <= 1'b0;
              fl_q     <= '0;
            end else begin
              fl_q <= fl_q + CW'(1);
            end
          end else if (lat_q == CW'(LAT)) begin
            vld_q <= 1'b1;
            bit_q <= core_bit_i;
          end else begin
            lat_q <= lat_q + CW'(1);
          end
        end
      end
    end
  end

  assign dec_vld_o = vld_q;
  assign dec_bit_o = bit_q;

  assert_out_follows_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(stage_done_i));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !vld_q);
  assert_flush_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q < CW'(LAT));
  assert_bit_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> bit_q == $past(core_bit_i));
endmodule

// File: rtl/soft_sample_link.sv
module soft_sample_link
  import ssl_pkg::*;
#(
  parameter int unsigned SMP_W = SMP_W_DEF,
  parameter int unsigned LAT   = LAT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  output logic             req_o,
  input  logic             x_ser_i,
  input  logic             y_ser_i,
  input  logic             bit_vld_i,
  output logic [SMP_W-1:0] x_smp_o,
  output logic [SMP_W-1:0] y_smp_o,
  output logic             pair_vld_o,
  input  logic             pair_rdy_i,
  output logic             stall_o,
  input  logic             stage_done_i,
  input  logic             core_bit_i,
  output logic             dec_bit_o,
  output logic             dec_vld_o
);
  logic             shift_en;
  logic             rise;
  logic             fall;
  logic [LANES-1:0] lane_ser;
  logic [SMP_W-1:0] lane_smp [LANES];

  assign lane_ser = {y_ser_i, x_ser_i};

  ssl_pair_ctrl #(.SMP_W(SMP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go_i),
    .bit_vld_i  (bit_vld_i),
    .pair_rdy_i (pair_rdy_i),
    .shift_en_o (shift_en),
    .pair_vld_o (pair_vld_o),
    .req_o      (req_o),
    .stall_o    (stall_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ssl_lane #(.SMP_W(SMP_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (shift_en),
      .ser_i (lane_ser[g]),
      .smp_o (lane_smp[g])
    );
  end

  assign x_smp_o = lane_smp[0];
  assign y_smp_o = lane_smp[1];

  ssl_out_seq #(.LAT(LAT)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rise),
    .fall_i       (fall),
    .stage_done_i (stage_done_i),
    .core_bit_i   (core_bit_i),
    .dec_bit_o    (dec_bit_o),
    .dec_vld_o    (dec_vld_o)
  );

  assert_hold_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_vld_o && !pair_rdy_i && !go_i == 1'b0 && !(go_i && !$past(go_i)))
      |=> ($stable(x_smp_o) && $stable(y_smp_o)));
endmodule

// File: tb/sim_soft_sample_link.sv
module sim_soft_sample_link;
  localparam int SW  = 3;
  localparam int LAT = 16;
  localparam logic [5:0] VEC [0:7] = '{6'o75, 6'o02, 6'o47, 6'o30, 6'o66, 6'o11, 6'o53, 6'o04};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, xs = 1'b0, ys = 1'b0, bv = 1'b0, rdy = 1'b0, sd = 1'b0, cb = 1'b0;
  logic req, pvld, stall, dbit, dvld;
  logic [SW-1:0] xsmp, ysmp;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  soft_sample_link #(.SMP_W(SW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go), .req_o(req),
    .x_ser_i(xs), .y_ser_i(ys), .bit_vld_i(bv),
    .x_smp_o(xsmp), .y_smp_o(ysmp), .pair_vld_o(pvld), .pair_rdy_i(rdy),
    .stall_o(stall), .stage_done_i(sd), .core_bit_i(cb),
    .dec_bit_o(dbit), .dec_vld_o(dvld)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_pair(input logic [SW-1:0] x, input logic [SW-1:0] y);
    for (int i = SW - 1; i >= 0; i--) begin
      bv = 1'b1; xs = x[i]; ys = y[i];
      step();
    end
    bv = 1'b0;
  endtask

  task automatic consume(input logic exp_req);
    rdy = 1'b1;
    #1 check("R5 no stall while pair held", stall, 0);
    step();
    rdy = 1'b0;
    check("R4 pair cleared after accept", pvld, 0);
    check("R4/R9 request after accept", req, exp_req);
    step();
    check("R8 request is one clock", req, 0);
  endtask

  task automatic stage(input logic b, input logic exp_v, input string tag);
    sd = 1'b1; cb = b;
    step();
    sd = 1'b0;
    check(tag, dvld, exp_v);
    if (exp_v) check({tag, " bit"}, dbit, b);
    step();
    check("R8 output valid is one clock", dvld, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(); step();
    check("R12 req in reset", req, 0);
    check("R12 pair_vld in reset", pvld, 0);
    rst_n = 1'b1;
    step();
    check("R12 req after reset", req, 0);
    check("R12 pair_vld after reset", pvld, 0);
    check("R12 stall after reset", stall, 0);
    check("R12 dec_vld after reset", dvld, 0);

    // R1: start pulse
    go = 1'b1;
    step();
    check("R1 request after start", req, 1);
    step();
    check("R8 start request is one clock", req, 0);

    // Vector table: assemble, present, accept
    for (int k = 0; k < 8; k++) begin
      send_pair(VEC[k][5:3], VEC[k][2:0]);
      check("R2 pair valid after three bits", pvld, 1);
      check("R3 x sample MSB first", xsmp, VEC[k][5:3]);
      check("R3 y sample MSB first", ysmp, VEC[k][2:0]);
      consume(1'b1);
    end

    // R5: stall when ready without a pair
    rdy = 1'b1;
    #1 check("R5 stall when ready and empty", stall, 1);
    step();
    rdy = 1'b0;
    #1 check("R5 no stall when not ready", stall, 0);

    // R6: extra bits while held are ignored
    send_pair(3'b101, 3'b010);
    send_pair(3'b010, 3'b101);
    check("R6 pair still valid", pvld, 1);
    check("R6 x sample unchanged", xsmp, 3'b101);
    check("R6 y sample unchanged", ysmp, 3'b010);
    consume(1'b1);

    // R7: silent window then output
    for (int s = 0; s < LAT; s++) stage(s[0], 1'b0, "R7 silent stage");
    stage(1'b1, 1'b1, "R7 first output stage");
    stage(1'b0, 1'b1, "R7 output stage");
    stage(1'b1, 1'b1, "R7 output stage");

    // R9: no request after go falls
    send_pair(3'b011, 3'b110);
    go = 1'b0;
    step();
    consume(1'b0);

    // R10: flush exactly LAT bits, then idle
    for (int s = 0; s < LAT; s++) stage(~s[1], 1'b1, "R10 flush output");
    stage(1'b1, 1'b0, "R10 idle after flush");

    // R11: restart gives a fresh silent window
    go = 1'b1;
    step();
    check("R11 request on restart", req, 1);
    step();
    for (int s = 0; s < LAT; s++) stage(1'b1, 1'b0, "R11 silent after restart");
    stage(1'b0, 1'b1, "R11 output after restart");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule